// File: doc/BRIEF.md
# Nibble Stack-Machine ALU

This block is the execute stage of a zero-address processor with a 4-bit datapath. Operands are never addressed: they live on a small expression stack held in flip-flops, and each operation implicitly works on the top entry (TOS) and the entry below it (TOS-1). A binary operation consumes both, writes its result as the new TOS and shrinks the stack by one, so the old TOS-2 becomes TOS-1. A unary operation (complement, shift, rotate) rewrites TOS in place. A condition code register holds a carry/borrow flag and a branch flag. Each operation code says how it sets them.

The stack holds `DEPTH` entries (default 8, and never fewer than five visible positions). A pointer gives the current depth. An operation that would push onto a full stack, or that needs more entries than the stack holds, is refused: the stack and the flags are left as they were, and a sticky error output rises and stays high until reset. Every result is registered. The effect of an operation code applied before a rising edge is visible on the outputs right after that edge.

Top module: `nstk_alu`

## Requirements
- R1: After reset, depth is 0, tos reads 0, and carry, branch and err are all 0.
- R2: PUSH (code 1) places push_data on top and DUP (code 15) places a copy of TOS on top, each raising depth by one. DROP (code 2) removes TOS and lowers depth by one. None of the three changes carry or branch.
- R3: A binary operation (codes 3 to 9) takes TOS-1 as the left operand and TOS as the right operand. The result becomes TOS, depth drops by one, and the old TOS-2 becomes TOS-1.
- R4: ADD (code 3) writes the 4-bit sum and sets carry to the carry-out. ADDC (code 4) also adds the incoming carry flag.
- R5: SUB (code 5) writes TOS-1 minus TOS and sets carry to 1 when the difference underflows. SUBB (code 6) also subtracts the incoming carry flag.
- R6: AND (7), OR (8), XOR (9) and NOT (10, complements TOS in place) leave carry unchanged. They set branch to 1 exactly when the result is zero.
- R7: SHL (code 11) and SHR (code 12) shift TOS in place by one bit, filling with zero. The bit shifted out goes to carry.
- R8: ROL (code 13) and ROR (code 14) rotate TOS in place through carry. The bit that leaves goes to carry, and the old carry fills the vacated bit.
- R9: After ADD, ADDC, SUB, SUBB, SHL, SHR, ROL and ROR, branch equals the new carry.
- R10: A push or DUP on a full stack, or an operation that needs more entries than depth, sets err. Stack contents, depth, carry and branch stay unchanged.
- R11: Once set, err stays 1 until reset, and later legal operations still execute.
- R12: NOP (code 0) changes no output.
- R13: The effect of an operation is visible on tos, depth and the flags in the cycle right after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code, sampled every rising edge |
| push_data | input | W | Value placed on the stack by PUSH |
| tos | output | W | Current top of stack (0 when empty) |
| depth | output | DW | Number of entries on the stack |
| carry | output | 1 | Carry/borrow flag |
| branch | output | 1 | Branch flag |
| err | output | 1 | Sticky stack fault flag |

## Verification
Every result, whether TOS, depth, carry, branch or err, is due exactly one rising edge after its operation code is applied. No result takes longer, because the whole operation is a single registered step. The bench drives each code on a falling edge and reads the outputs on the next falling edge, half a period after the edge that commits them, so each read sees one completed operation. Entries deeper than TOS are checked by dropping down to them through DROP. Checks on refused operations read tos, depth and the flags on the falling edge right after the refused code.

// File: rtl/nstk_pkg.sv
package nstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_PUSH = 4'd1,
        OP_DROP = 4'd2,
        OP_ADD  = 4'd3,
        OP_ADDC = 4'd4,
        OP_SUB  = 4'd5,
        OP_SUBB = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_NOT  = 4'd10,
        OP_SHL  = 4'd11,
        OP_SHR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ROR  = 4'd14,
        OP_DUP  = 4'd15
    } nstk_op_e;

    // How a legal operation moves the stack pointer
    typedef enum logic [1:0] {
        MV_HOLD   = 2'd0,
        MV_GROW   = 2'd1,
        MV_SHRINK = 2'd2,
        MV_KEEP   = 2'd3
    } nstk_move_e;

endpackage

// File: rtl/nstk_guard.sv
module nstk_guard
    import nstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  nstk_op_e        op,
    input  logic [DW-1:0]   depth,
    output nstk_move_e      move,
    output logic            fault
);

    logic [DW-1:0] need;
    logic          grows;
    nstk_move_e    move_raw;

    always_comb begin
        need     = '0;
        grows    = 1'b0;
        move_raw = MV_HOLD;
        unique case (op)
            OP_NOP:  move_raw = MV_HOLD;
            OP_PUSH: begin
                grows    = 1'b1;
                move_raw = MV_GROW;
            end
            OP_DUP: begin
                need     = DW'(1);
                grows    = 1'b1;
                move_raw = MV_GROW;
            end
            OP_DROP: begin
                need     = DW'(1);
                move_raw = MV_SHRINK;
            end
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_AND, OP_OR, OP_XOR: begin
                need     = DW'(2);
                move_raw = MV_SHRINK;
            end
            default: begin
                need     = DW'(1);
                move_raw = MV_KEEP;
            end
        endcase
        fault = (depth < need) || (grows && (depth == DW'(DEPTH)));
        move  = fault ? MV_HOLD : move_raw;
    end

endmodule

// File: rtl/nstk_alu_core.sv
module nstk_alu_core
    import nstk_pkg::*;
#(
    parameter int W = 4
) (
    input  nstk_op_e      op,
    input  logic [W-1:0]  lhs,
    input  logic [W-1:0]  rhs,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          cout,
    output logic          bout,
    output logic          sets_flags
);

    logic [W:0] wide_d;
    logic       use_cin;

    always_comb begin
        use_cin    = (op == OP_ADDC) || (op == OP_SUBB);
        wide_d     = '0;
        res        = rhs;
        cout       = cin;
        bout       = 1'b0;
        sets_flags = 1'b1;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                wide_d = {1'b0, lhs} + {1'b0, rhs} + (W+1)'(use_cin & cin);
                res    = wide_d[W-1:0];
                cout   = wide_d[W];
                bout   = wide_d[W];
            end
            OP_SUB, OP_SUBB: begin
                wide_d = {1'b0, lhs} - {1'b0, rhs} - (W+1)'(use_cin & cin);
                res    = wide_d[W-1:0];
                cout   = wide_d[W];
                bout   = wide_d[W];
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                unique case (op)
                    OP_AND:  res = lhs & rhs;
                    OP_OR:   res = lhs | rhs;
                    OP_XOR:  res = lhs ^ rhs;
                    default: res = ~rhs;
                endcase
                cout = cin;
                bout = (res == '0);
            end
            OP_SHL: begin
                res  = {rhs[W-2:0], 1'b0};
                cout = rhs[W-1];
                bout = rhs[W-1];
            end
            OP_SHR: begin
                res  = {1'b0, rhs[W-1:1]};
                cout = rhs[0];
                bout = rhs[0];
            end
            OP_ROL: begin
                res  = {rhs[W-2:0], cin};
                cout = rhs[W-1];
                bout = rhs[W-1];
            end
            OP_ROR: begin
                res  = {cin, rhs[W-1:1]};
                cout = rhs[0];
                bout = rhs[0];
            end
            default: sets_flags = 1'b0;
        endcase
    end

endmodule

// File: rtl/nstk_alu.sv
module nstk_alu
    import nstk_pkg::*;
#(
    parameter  int W     = 4,
    parameter  int DEPTH = 8,
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op,
    input  logic [W-1:0]  push_data,
    output logic [W-1:0]  tos,
    output logic [DW-1:0] depth,
    output logic          carry,
    output logic          branch,
    output logic          err
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [DW-1:0]           ptr;
        logic                    cy;
        logic                    br;
        logic                    err;
    } stk_state_t;

    stk_state_t st_d, st_q;

    nstk_op_e   op_e;
    nstk_move_e move;
    logic       fault;
    logic [PW-1:0] top_idx, nos_idx, new_idx;
    logic [W-1:0]  tos_v, nos_v, alu_res;
    logic          alu_cy, alu_br, alu_sets;

    assign op_e    = nstk_op_e'(op);
    assign top_idx = PW'(st_q.ptr - DW'(1));
    assign nos_idx = PW'(st_q.ptr - DW'(2));
    assign new_idx = PW'(st_q.ptr);
    assign tos_v   = (st_q.ptr == '0)    ? '0 : st_q.mem[top_idx];
    assign nos_v   = (st_q.ptr < DW'(2)) ? '0 : st_q.mem[nos_idx];

    nstk_guard #(.DEPTH(DEPTH), .DW(DW)) u_guard (
        .op    (op_e),
        .depth (st_q.ptr),
        .move  (move),
        .fault (fault)
    );

    nstk_alu_core #(.W(W)) u_core (
        .op         (op_e),
        .lhs        (nos_v),
        .rhs        (tos_v),
        .cin        (st_q.cy),
        .res        (alu_res),
        .cout       (alu_cy),
        .bout       (alu_br),
        .sets_flags (alu_sets)
    );

    always_comb begin
        st_d = st_q;
        if (fault) begin
            st_d.err = 1'b1;
        end
        unique case (move)
            MV_GROW: begin
                st_d.mem[new_idx] = (op_e == OP_DUP) ? tos_v : push_data;
                st_d.ptr          = st_q.ptr + DW'(1);
            end
            MV_SHRINK: begin
                if (op_e != OP_DROP) begin
                    st_d.mem[nos_idx] = alu_res;
                end
                st_d.ptr = st_q.ptr - DW'(1);
            end
            MV_KEEP: st_d.mem[top_idx] = alu_res;
            default: ;
        endcase
        if ((move != MV_HOLD) && alu_sets) begin
            st_d.cy = alu_cy;
            st_d.br = alu_br;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tos    = tos_v;
    assign depth  = st_q.ptr;
    assign carry  = st_q.cy;
    assign branch = st_q.br;
    assign err    = st_q.err;

endmodule

// File: rtl/nstk_alu_chk.sv
module nstk_alu_chk #(
    parameter int W     = 4,
    parameter int DEPTH = 8,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op,
    input logic [W-1:0]  push_data,
    input logic [W-1:0]  tos,
    input logic [DW-1:0] depth,
    input logic          carry,
    input logic          branch,
    input logic          err
);

    logic is_bin, is_logic, is_arith;
    assign is_bin   = (op >= 4'd3) && (op <= 4'd9);
    assign is_logic = (op >= 4'd7) && (op <= 4'd10);
    assign is_arith = ((op >= 4'd3) && (op <= 4'd6)) || ((op >= 4'd11) && (op <= 4'd14));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1 && depth == DW'(DEPTH)) |=> (err && $stable(depth) && $stable(tos)));

    // R3
    collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bin && depth >= DW'(2)) |=> (depth == $past(depth) - DW'(1)));

    // R6
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && depth >= DW'(2)) |=> (carry == $past(carry)));

    // R9
    arith_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_arith && depth >= DW'(2)) |=> (branch == carry));

    // R12
    nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd0) |=> ($stable(depth) && $stable(tos) && $stable(carry) && $stable(branch)));

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1 && depth < DW'(DEPTH)) |=> (tos == $past(push_data) && depth == $past(depth) + DW'(1)));

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_bound_chk: assert (depth <= DW'(DEPTH));
        end
    end

endmodule

bind nstk_alu nstk_alu_chk #(.W(W), .DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .push_data (push_data),
    .tos       (tos),
    .depth     (depth),
    .carry     (carry),
    .branch    (branch),
    .err       (err)
);

// File: tb/nstk_alu_bench.sv
module nstk_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int DEPTH      = 8;
    localparam int DW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op = 4'd0;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  tos;
    logic [DW-1:0] depth;
    logic          carry, branch, err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nstk_alu #(.W(W), .DEPTH(DEPTH)) u_nstk_alu (
        .clk(clk), .rst_n(rst_n), .op(op), .push_data(push_data),
        .tos(tos), .depth(depth), .carry(carry), .branch(branch), .err(err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<5000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // drive on falling edge, result is readable at the next falling edge
    task automatic step(input logic [3:0] code, input logic [W-1:0] d);
        @(negedge clk);
        op        = code;
        push_data = d;
        @(negedge clk);
        op        = 4'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op    = 4'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 depth", depth, 0);
        chk("R1 tos", tos, 0);
        chk("R1 carry", carry, 0);
        chk("R1 branch", branch, 0);
        chk("R1 err", err, 0);
    endtask

    task automatic t_push_dup_drop();
        do_reset();
        step(4'd1, 4'd5);
        step(4'd1, 4'd3);
        chk("R2 push tos", tos, 3);
        chk("R13 push depth", depth, 2);
        step(4'd15, 4'd0);
        chk("R2 dup tos", tos, 3);
        chk("R2 dup depth", depth, 3);
        step(4'd2, 4'd0);
        chk("R2 drop depth", depth, 2);
        step(4'd2, 4'd0);
        chk("R2 drop tos", tos, 5);
        chk("R2 flags kept", {carry, branch}, 0);
    endtask

    task automatic t_collapse();
        do_reset();
        step(4'd1, 4'd1);
        step(4'd1, 4'd2);
        step(4'd1, 4'd3);
        step(4'd3, 4'd0);
        chk("R3 add tos", tos, 5);
        chk("R3 depth", depth, 2);
        step(4'd2, 4'd0);
        chk("R3 old TOS-2 surfaced", tos, 1);
    endtask

    task automatic t_add();
        do_reset();
        step(4'd1, 4'd9);
        step(4'd1, 4'd8);
        step(4'd3, 4'd0);
        chk("R4 add wrap", tos, 1);
        chk("R4 carry out", carry, 1);
        chk("R9 branch=carry", branch, 1);
        step(4'd1, 4'd2);
        step(4'd4, 4'd0);
        chk("R4 addc sum", tos, 4);
        chk("R4 addc carry", carry, 0);
        chk("R9 addc branch", branch, 0);
    endtask

    task automatic t_sub();
        do_reset();
        step(4'd1, 4'd7);
        step(4'd1, 4'd2);
        step(4'd5, 4'd0);
        chk("R5 sub no borrow", tos, 5);
        chk("R5 borrow clear", carry, 0);
        step(4'd1, 4'd3);
        step(4'd1, 4'd5);
        step(4'd5, 4'd0);
        chk("R5 sub order", tos, 14);
        chk("R5 borrow set", carry, 1);
        chk("R9 sub branch", branch, 1);
        step(4'd1, 4'd1);
        step(4'd6, 4'd0);
        chk("R5 subb", tos, 12);
        chk("R5 subb borrow", carry, 0);
    endtask

    task automatic t_logic();
        do_reset();
        step(4'd1, 4'd15);
        step(4'd1, 4'd1);
        step(4'd3, 4'd0);
        chk("R6 setup carry", carry, 1);
        step(4'd1, 4'd12);
        step(4'd1, 4'd3);
        step(4'd7, 4'd0);
        chk("R6 and", tos, 0);
        chk("R6 and branch", branch, 1);
        chk("R6 and carry kept", carry, 1);
        step(4'd1, 4'd5);
        step(4'd8, 4'd0);
        chk("R6 or", tos, 5);
        chk("R6 or branch", branch, 0);
        step(4'd1, 4'd5);
        step(4'd9, 4'd0);
        chk("R6 xor", tos, 0);
        chk("R6 xor branch", branch, 1);
        step(4'd10, 4'd0);
        chk("R6 not", tos, 15);
        chk("R6 not branch", branch, 0);
        chk("R6 not carry kept", carry, 1);
    endtask

    task automatic t_shift();
        do_reset();
        step(4'd1, 4'd9);
        step(4'd11, 4'd0);
        chk("R7 shl", tos, 2);
        chk("R7 shl carry", carry, 1);
        chk("R9 shl branch", branch, 1);
        step(4'd12, 4'd0);
        chk("R7 shr", tos, 1);
        chk("R7 shr carry", carry, 0);
    endtask

    task automatic t_rotate();
        do_reset();
        step(4'd1, 4'd9);
        step(4'd13, 4'd0);
        chk("R8 rol1", tos, 2);
        chk("R8 rol1 carry", carry, 1);
        step(4'd13, 4'd0);
        chk("R8 rol2 takes carry", tos, 5);
        chk("R8 rol2 carry", carry, 0);
        step(4'd14, 4'd0);
        chk("R8 ror1", tos, 2);
        chk("R8 ror1 carry", carry, 1);
        step(4'd14, 4'd0);
        chk("R8 ror2 takes carry", tos, 9);
        chk("R9 ror branch", branch, 0);
    endtask

    task automatic t_faults();
        do_reset();
        step(4'd3, 4'd0);
        chk("R10 empty add err", err, 1);
        chk("R10 empty add depth", depth, 0);
        do_reset();
        step(4'd1, 4'd6);
        step(4'd5, 4'd0);
        chk("R10 one-entry sub err", err, 1);
        chk("R10 one-entry sub tos", tos, 6);
        chk("R10 one-entry sub flags", {carry, branch}, 0);
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(4'd1, 4'(i));
        chk("R10 full depth", depth, DEPTH);
        step(4'd1, 4'd15);
        chk("R10 full push err", err, 1);
        chk("R10 full push depth", depth, DEPTH);
        chk("R10 full push tos", tos, DEPTH - 1);
        step(4'd15, 4'd0);
        chk("R10 full dup depth", depth, DEPTH);
        step(4'd2, 4'd0);
        chk("R11 legal op after err", tos, DEPTH - 2);
        chk("R11 err sticky", err, 1);
    endtask

    task automatic t_nop();
        do_reset();
        step(4'd1, 4'd9);
        step(4'd1, 4'd8);
        step(4'd3, 4'd0);
        step(4'd0, 4'd0);
        step(4'd0, 4'd7);
        chk("R12 nop tos", tos, 1);
        chk("R12 nop depth", depth, 1);
        chk("R12 nop flags", {carry, branch}, 3);
    endtask

    initial begin
        t_reset();
        t_push_dup_drop();
        t_collapse();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_rotate();
        t_faults();
        t_nop();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule